// File: doc/BRIEF.md
# Dual-Channel DAC Command Interface

This block is the digital front end of a two-channel 10-bit voltage DAC. A host sends it 16-bit command words over a three-wire serial link: a select/load strobe, a serial clock and a data line. While the strobe is low, each rising serial clock edge shifts one data bit in. When the strobe returns high, the block decodes a 4-bit control code taken from the top of the word and acts on it.

Each channel has two registers. The input register is a staging register. The DAC register drives the converter code. Channels can be staged one at a time, even while the block sleeps. The DAC registers are always refreshed together, and several control codes combine staging, refresh and wake-up into one command.

The block also keeps a sleep/wake state. During sleep, both output-enable lines drop so the analog outputs go to high impedance, and all register contents are kept. The serial lines are sampled as ordinary inputs of the system clock domain. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `dac_cmd_if`

## Requirements
- R1: After reset, both DAC codes are zero, both drive enables are high and `asleep` is low.
- R2: Bits are captured MSB first on rising `ser_clk` edges while `ld_sel` is low. Word bits 15:12 are the control code and bits 11:2 are the 10-bit data. Bits 1:0 are ignored.
- R3: `ser_clk` edges that occur while `ld_sel` is high change no register.
- R4: A command takes effect only if exactly 16 bits were shifted since `ld_sel` fell. Frames of 15 or 17 bits are discarded.
- R5: Code 0001 stages the data into channel A's input register, and code 0010 stages it into channel B's. Neither changes the DAC codes or the sleep state.
- R6: Code 1000 copies both input registers into both DAC registers and clears sleep.
- R7: Code 1001 (or 1010) stages the data into channel A (or B), then refreshes both DAC registers and clears sleep. The other channel's DAC register receives its previously staged value.
- R8: Code 1101 clears sleep and leaves every code register unchanged.
- R9: Code 1110 sets sleep, ignores the data field and keeps all codes. While asleep, `asleep` is high and both drive enables are low until a waking command runs.
- R10: Code 1111 stages the same data into both input registers, then refreshes both DAC registers and clears sleep.
- R11: Code 0000 and every code not named in R5 to R10 change no register and no sleep state.
- R12: Outputs change only in response to a complete command. New values appear on the fourth rising system clock edge, counting the first edge that samples `ld_sel` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_sel | input | 1 | Serial select/load strobe; shifting while low, execute on its rise |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, MSB first |
| dac_code_a | output | 10 | Channel A converter code |
| dac_code_b | output | 10 | Channel B converter code |
| drive_en_a | output | 1 | Channel A output drive enable (low = high impedance) |
| drive_en_b | output | 1 | Channel B output drive enable (low = high impedance) |
| asleep | output | 1 | Sleep state flag |

## Verification
The risky overlap is codes 1001 and 1010. In one command, each writes an input register and also copies both input registers into the DAC registers. The refresh must therefore take the freshly staged word for one channel and the older staged word for the other. The bench provokes this by staging different values per channel, some of them during sleep, before issuing a combined load-and-refresh code. A behavioural model compares both codes and the sleep state against the outputs on every clock, so a stale or doubly loaded channel shows up as a mismatch on the exact cycle of the refresh.

// File: rtl/dcif_pkg.sv
package dcif_pkg;
  localparam int CTRL_W = 4;

  typedef enum logic [CTRL_W-1:0] {
    OP_NOP        = 4'b0000,
    OP_STAGE_A    = 4'b0001,
    OP_STAGE_B    = 4'b0010,
    OP_REFRESH    = 4'b1000,
    OP_STAGE_A_RF = 4'b1001,
    OP_STAGE_B_RF = 4'b1010,
    OP_WAKE       = 4'b1101,
    OP_SLEEP      = 4'b1110,
    OP_STAGE_2_RF = 4'b1111
  } op_e;
endpackage

// File: rtl/dcif_sync.sv
module dcif_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_nxt;
      if (s == 0) begin : g_first
        always_comb stg_nxt = d;
      end else begin : g_rest
        always_comb stg_nxt = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg_nxt;
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcif_shifter.sv
module dcif_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_s,
  input  logic               sck_s,
  input  logic               dat_s,
  output logic               cmd_v,
  output logic [FRAME_W-1:0] cmd_word
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sel_d, sck_d;
  logic [FRAME_W-1:0] shreg, shreg_nxt;
  logic [CNT_W-1:0]   cnt, cnt_nxt;
  logic               cmd_v_nxt;
  logic               sck_rise, sel_rise, shift_en;

  always_comb begin
    sck_rise  = sck_s & ~sck_d;
    sel_rise  = sel_s & ~sel_d;
    shift_en  = sck_rise & ~sel_s;
    shreg_nxt = shift_en ? {shreg[FRAME_W-2:0], dat_s} : shreg;
    if (sel_s)
      cnt_nxt = '0;
    else if (shift_en && (cnt != CNT_W'(CNT_MAX)))
      cnt_nxt = cnt + CNT_W'(1);
    else
      cnt_nxt = cnt;
    cmd_v_nxt = sel_rise && (cnt == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d    <= 1'b0;
      sck_d    <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      cmd_v    <= 1'b0;
      cmd_word <= '0;
    end else begin
      sel_d <= sel_s;
      sck_d <= sck_s;
      cnt   <= cnt_nxt;
      cmd_v <= cmd_v_nxt;
      if (shift_en)  shreg    <= shreg_nxt;
      if (cmd_v_nxt) cmd_word <= shreg;
    end
  end
endmodule

// File: rtl/dcif_regbank.sv
module dcif_regbank
  import dcif_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_v,
  input  logic [CTRL_W+DATA_W+PAD_W-1:0] cmd_word,
  output logic [DATA_W-1:0]               out_a,
  output logic [DATA_W-1:0]               out_b,
  output logic                            sleep_q
);
  localparam int FRAME_W = CTRL_W + DATA_W + PAD_W;

  logic [DATA_W-1:0] in_a, in_b;
  logic [DATA_W-1:0] in_a_nxt, in_b_nxt, out_a_nxt, out_b_nxt;
  logic              sleep_nxt;
  logic              ld_a, ld_b, refresh, wake, go_sleep;
  op_e               op;
  logic [DATA_W-1:0] data;

  always_comb begin
    op       = op_e'(cmd_word[FRAME_W-1 -: CTRL_W]);
    data     = cmd_word[PAD_W +: DATA_W];
    ld_a     = 1'b0;
    ld_b     = 1'b0;
    refresh  = 1'b0;
    wake     = 1'b0;
    go_sleep = 1'b0;
    case (op)
      OP_STAGE_A:    ld_a = 1'b1;
      OP_STAGE_B:    ld_b = 1'b1;
      OP_REFRESH:    begin refresh = 1'b1; wake = 1'b1; end
      OP_STAGE_A_RF: begin ld_a = 1'b1; refresh = 1'b1; wake = 1'b1; end
      OP_STAGE_B_RF: begin ld_b = 1'b1; refresh = 1'b1; wake = 1'b1; end
      OP_WAKE:       wake = 1'b1;
      OP_SLEEP:      go_sleep = 1'b1;
      OP_STAGE_2_RF: begin ld_a = 1'b1; ld_b = 1'b1; refresh = 1'b1; wake = 1'b1; end
      default:       ;
    endcase
    in_a_nxt  = ld_a ? data : in_a;
    in_b_nxt  = ld_b ? data : in_b;
    out_a_nxt = refresh ? in_a_nxt : out_a;
    out_b_nxt = refresh ? in_b_nxt : out_b;
    sleep_nxt = go_sleep ? 1'b1 : (wake ? 1'b0 : sleep_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a    <= '0;
      in_b    <= '0;
      out_a   <= '0;
      out_b   <= '0;
      sleep_q <= 1'b0;
    end else if (cmd_v) begin
      in_a    <= in_a_nxt;
      in_b    <= in_b_nxt;
      out_a   <= out_a_nxt;
      out_b   <= out_b_nxt;
      sleep_q <= sleep_nxt;
    end
  end
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
  import dcif_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_sel,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DATA_W-1:0] dac_code_a,
  output logic [DATA_W-1:0] dac_code_b,
  output logic              drive_en_a,
  output logic              drive_en_b,
  output logic              asleep
);
  localparam int FRAME_W = CTRL_W + DATA_W + PAD_W;

  logic [2:0]         pins_s;
  logic               cmd_v;
  logic [FRAME_W-1:0] cmd_word;
  logic               sleep_q;

  dcif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ld_sel, ser_clk, ser_dat}),
    .q     (pins_s)
  );

  dcif_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (pins_s[2]),
    .sck_s    (pins_s[1]),
    .dat_s    (pins_s[0]),
    .cmd_v    (cmd_v),
    .cmd_word (cmd_word)
  );

  dcif_regbank #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_v    (cmd_v),
    .cmd_word (cmd_word),
    .out_a    (dac_code_a),
    .out_b    (dac_code_b),
    .sleep_q  (sleep_q)
  );

  assign asleep     = sleep_q;
  assign drive_en_a = ~sleep_q;
  assign drive_en_b = ~sleep_q;
endmodule

// File: rtl/dcif_chk.sv
module dcif_chk #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_v,
  input logic [FRAME_W-1:0] cmd_word,
  input logic [DATA_W-1:0]  dac_code_a,
  input logic [DATA_W-1:0]  dac_code_b,
  input logic               drive_en_a,
  input logic               drive_en_b,
  input logic               asleep
);
  logic [3:0] ctl;
  assign ctl = cmd_word[FRAME_W-1 -: 4];

  AST_CODES_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_v |=> $stable(dac_code_a) && $stable(dac_code_b) && $stable(asleep)); // R12

  AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |=> !cmd_v); // R12

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b0001 || ctl == 4'b0010)
      |=> $stable(dac_code_a) && $stable(dac_code_b) && $stable(asleep)); // R5

  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b0000) |=> $stable(dac_code_a) && $stable(dac_code_b) && $stable(asleep)); // R11

  AST_REFRESH_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b1000) |=> !asleep && drive_en_a && drive_en_b); // R6

  AST_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b1110)
      |=> asleep && !drive_en_a && !drive_en_b && $stable(dac_code_a) && $stable(dac_code_b)); // R9

  AST_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b1101) |=> !asleep && $stable(dac_code_a) && $stable(dac_code_b)); // R8

  AST_BOTH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v && (ctl == 4'b1111)
      |=> (dac_code_a == dac_code_b) && (dac_code_a == $past(cmd_word[FRAME_W-5 -: DATA_W]))); // R10
endmodule

bind dac_cmd_if dcif_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_v      (cmd_v),
  .cmd_word   (cmd_word),
  .dac_code_a (dac_code_a),
  .dac_code_b (dac_code_b),
  .drive_en_a (drive_en_a),
  .drive_en_b (drive_en_b),
  .asleep     (asleep)
);

// File: tb/tb_dac_cmd_if.sv
`timescale 1ns/1ps
module tb_dac_cmd_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_sel = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [9:0] dac_code_a, dac_code_b;
  logic drive_en_a, drive_en_b, asleep;

  always #2.5 clk = ~clk;

  dac_cmd_if dut (
    .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dac_code_a(dac_code_a), .dac_code_b(dac_code_b),
    .drive_en_a(drive_en_a), .drive_en_b(drive_en_b), .asleep(asleep)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  int m_in_a = 0, m_in_b = 0, m_out_a = 0, m_out_b = 0;
  bit m_sleep = 1'b0;
  int p_a[4], p_b[4];
  bit p_s[4];

  task automatic model_apply(input int c, input int d);
    case (c)
      1:  m_in_a = d;
      2:  m_in_b = d;
      8:  begin m_out_a = m_in_a; m_out_b = m_in_b; m_sleep = 0; end
      9:  begin m_in_a = d; m_out_a = m_in_a; m_out_b = m_in_b; m_sleep = 0; end
      10: begin m_in_b = d; m_out_a = m_in_a; m_out_b = m_in_b; m_sleep = 0; end
      13: m_sleep = 0;
      14: m_sleep = 1;
      15: begin m_in_a = d; m_in_b = d; m_out_a = d; m_out_b = d; m_sleep = 0; end
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the delayed model (four-edge latency, R12)
  always @(posedge clk) begin
    #1;
    for (int i = 3; i > 0; i--) begin
      p_a[i] = p_a[i-1]; p_b[i] = p_b[i-1]; p_s[i] = p_s[i-1];
    end
    p_a[0] = m_out_a; p_b[0] = m_out_b; p_s[0] = m_sleep;
    if (mon_on) begin
      n_cmp++;
      if (int'(dac_code_a) != p_a[3] || int'(dac_code_b) != p_b[3] || asleep != p_s[3] ||
          drive_en_a != !p_s[3] || drive_en_b != !p_s[3]) begin
        n_bad++;
        $display("FAIL %s clock-compare: a=%0h b=%0h slp=%0b en=%0b%0b expected a=%0h b=%0h slp=%0b",
                 cur_req, dac_code_a, dac_code_b, asleep, drive_en_a, drive_en_b,
                 p_a[3], p_b[3], p_s[3]);
      end
    end
  end

  task automatic send(input int c, input int d, input int pad, input int nbits);
    logic [15:0] w;
    w = {c[3:0], d[9:0], pad[1:0]};
    @(negedge clk);
    ser_clk = 1'b0; ld_sel = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 16) ? w[15-i] : 1'b1;
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    ld_sel = 1'b1;
    if (nbits == 16) model_apply(c, d);
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_now(input string req, input int a, input int b, input bit s);
    chk(req, "dac_code_a", int'(dac_code_a), a);
    chk(req, "dac_code_b", int'(dac_code_b), b);
    chk(req, "asleep", int'(asleep), int'(s));
    chk(req, "drive_en_a", int'(drive_en_a), int'(!s));
    chk(req, "drive_en_b", int'(drive_en_b), int'(!s));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin p_a[i] = 0; p_b[i] = 0; p_s[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    expect_now("R1", 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R1", 0, 0, 0);
    mon_on = 1'b1;

    // R10 / R2: same code to both, nonzero pad bits ignored
    cur_req = "R10"; send(15, 'h2A5, 3, 16);
    expect_now("R10", 'h2A5, 'h2A5, 0);

    // R5: staging only, outputs hold
    cur_req = "R5"; send(1, 'h3C1, 2, 16); send(2, 'h00F, 1, 16);
    expect_now("R5", 'h2A5, 'h2A5, 0);

    // R6 / R2: refresh shows MSB-first capture of staged data
    cur_req = "R6"; send(8, 'h155, 0, 16);
    expect_now("R2", 'h3C1, 'h00F, 0);

    // R7: load-and-refresh, other channel takes its older staged value
    cur_req = "R7"; send(1, 'h200, 0, 16); send(10, 'h0AA, 0, 16);
    expect_now("R7", 'h200, 'h0AA, 0);
    send(9, 'h155, 0, 16);
    expect_now("R7", 'h155, 'h0AA, 0);

    // R9: sleep keeps codes, data ignored
    cur_req = "R9"; send(14, 'h3FF, 3, 16);
    expect_now("R9", 'h155, 'h0AA, 1);
    cur_req = "R5"; send(1, 'h111, 0, 16);
    expect_now("R9", 'h155, 'h0AA, 1);

    // R8: wake only
    cur_req = "R8"; send(13, 'h3AB, 0, 16);
    expect_now("R8", 'h155, 'h0AA, 0);

    // R7 from sleep with both channels staged
    cur_req = "R7"; send(14, 0, 0, 16); send(2, 'h222, 0, 16);
    expect_now("R9", 'h155, 'h0AA, 1);
    send(9, 'h333, 0, 16);
    expect_now("R7", 'h333, 'h222, 0);

    // R11: no-op and undefined codes
    cur_req = "R11";
    send(0, 'h001, 0, 16); send(3, 'h002, 0, 16); send(4, 'h003, 0, 16);
    send(7, 'h004, 0, 16); send(11, 'h005, 0, 16); send(12, 'h006, 0, 16);
    send(14, 0, 0, 16); send(5, 'h007, 0, 16);
    expect_now("R11", 'h333, 'h222, 1);
    send(8, 0, 0, 16);
    expect_now("R11", 'h333, 'h222, 0);

    // R4: wrong frame lengths discarded
    cur_req = "R4"; send(15, 'h001, 0, 15); send(15, 'h002, 0, 17);
    expect_now("R4", 'h333, 'h222, 0);
    send(8, 0, 0, 16);
    expect_now("R4", 'h333, 'h222, 0);

    // R3: serial clock activity with select high
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); ser_dat = i[0]; ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    expect_now("R3", 'h333, 'h222, 0);
    send(8, 0, 0, 16);
    expect_now("R3", 'h333, 'h222, 0);

    cur_req = "R12"; send(15, 'h3FF, 0, 16);
    expect_now("R12", 'h3FF, 'h3FF, 0);
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule